// File: doc/BRIEF.md
# Five-Bit ALU with Registered Result Hold

This block is a small arithmetic and logic unit whose result, carry and zero indication all live in registers. On every rising clock edge it samples two 5-bit operands and a 3-bit opcode, then computes the next register contents. The top opcode bit acts as a negate/test selector and the low two bits pick the operation group. Only four encodings are defined: bitwise AND, ripple-carry subtraction, a conditional clear when the operands are equal, and forcing the carry high.

Some operations leave the stored result unchanged. The combinational next-state logic therefore starts from the current register value as its default. It never relies on a storage element that is not clocked. Every output has a defined value in every cycle. The block is used wherever a one-cycle registered ALU slice is needed and the result must be able to persist across operations.

Top module: `alu5_hold`

## Requirements
- R1: While `rst` is high at a rising edge, the next state clears `res`, `cout` and `zero` to 0.
- R2: Outputs come only from registers. A change on `a`, `b` or `op` between edges leaves the outputs unchanged until the next rising edge.
- R3: Opcode 3'b000 stores `a & b` in `res`, and `cout` keeps its previous value.
- R4: Opcode 3'b110 stores `a + ~b + 1` modulo 32 in `res`. `cout` takes the final ripple carry, which is 1 exactly when `a >= b` as unsigned values.
- R5: Opcode 3'b011 stores 5'b00000 when `a == b`. Otherwise `res` keeps its previous value. `cout` keeps its previous value in both cases.
- R6: Opcode 3'b111 sets `cout` to 1, and `res` keeps its previous value.
- R7: Opcodes 3'b001, 3'b010, 3'b100 and 3'b101 clear both `res` and `cout` to 0.
- R8: After each edge with `rst` low, `zero` is 1 exactly when the newly stored `res` is 5'b00000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a | input | 5 | First operand |
| b | input | 5 | Second operand |
| op | input | 3 | Opcode: bit 2 negate/test select, bits 1:0 operation group |
| res | output | 5 | Registered result |
| cout | output | 1 | Registered carry-out |
| zero | output | 1 | Registered flag, high when the stored result is zero |

## Verification
Every result of this block is due exactly one rising edge after the operands and opcode are applied. This holds for results that hold or force the carry too. The driver applies inputs on the falling edge and queues the expected register contents. The monitor compares them just after the following rising edge, so each queued item meets exactly the edge that produced it. The driver also samples the outputs shortly after it changes the inputs and before the edge. This shows that nothing moves mid-cycle.

// File: rtl/alu5_hold.sv
module alu5_hold #(
  parameter int W  = 5,
  parameter int OW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [OW-1:0] op,
  output logic [W-1:0]  res,
  output logic          cout,
  output logic          zero
);

  localparam logic [OW-1:0] OP_AND = 3'b000;
  localparam logic [OW-1:0] OP_SEQ = 3'b011;
  localparam logic [OW-1:0] OP_SUB = 3'b110;
  localparam logic [OW-1:0] OP_SCO = 3'b111;
  localparam logic [W-1:0]  ZERO_W = '0;

  logic [W-1:0] nb, diff, res_d;
  logic [W:0]   cy;
  logic         cout_d;

  assign nb    = ~b;
  assign cy[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_ripple
    assign diff[i]  = a[i] ^ nb[i] ^ cy[i];
    assign cy[i+1]  = (a[i] & nb[i]) | (nb[i] & cy[i]) | (cy[i] & a[i]);
  end

  always_comb begin
    res_d  = res;
    cout_d = cout;
    case (op)
      OP_AND: res_d = a & b;
      OP_SUB: begin
        res_d  = diff;
        cout_d = cy[W];
      end
      OP_SEQ: if (a == b) res_d = ZERO_W;
      OP_SCO: cout_d = 1'b1;
      default: begin
        res_d  = ZERO_W;
        cout_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res  <= ZERO_W;
      cout <= 1'b0;
      zero <= 1'b0;
    end else begin
      res  <= res_d;
      cout <= cout_d;
      zero <= (res_d == ZERO_W);
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (res == ZERO_W && !cout && !zero)); // R1
  AST_AND_RESULT: assert property (@(posedge clk) disable iff (rst)
    (op == OP_AND) |=> (res == ($past(a) & $past(b)) && cout == $past(cout))); // R3
  AST_SUB_RESULT: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SUB) |=> ({cout, res} == ({1'b0, $past(a)} + {1'b0, ~$past(b)} + 6'd1))); // R4
  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SEQ && a != b) |=> ($stable(res) && $stable(cout))); // R5
  AST_SEQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SEQ && a == b) |=> (res == ZERO_W && $stable(cout))); // R5
  AST_SCO_SET: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SCO) |=> (cout && $stable(res))); // R6
  AST_UNDEF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (op == 3'b001 || op == 3'b010 || op == 3'b100 || op == 3'b101) |=> (res == ZERO_W && !cout)); // R7
  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (zero == (res == ZERO_W))); // R8

endmodule

// File: tb/alu5_hold_test.sv
module alu5_hold_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] a = '0, b = '0;
  logic [2:0] op = '0;
  logic [4:0] res;
  logic       cout, zero;

  int checks = 0, errors = 0;
  logic [4:0] m_res = '0;
  logic       m_cout = 1'b0, m_zero = 1'b0;
  logic [6:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  always #2 clk = ~clk;

  alu5_hold uut (.clk(clk), .rst(rst), .a(a), .b(b), .op(op),
                 .res(res), .cout(cout), .zero(zero));

  function automatic string req_of(input logic r, input logic [2:0] o);
    if (r) return "R1";
    case (o)
      3'b000: return "R3";
      3'b110: return "R4";
      3'b011: return "R5";
      3'b111: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic r, input logic [4:0] va, input logic [4:0] vb, input logic [2:0] vo);
    @(negedge clk);
    rst = r; a = va; b = vb; op = vo;
    #1;
    checks++;
    if ({res, cout, zero} !== {m_res, m_cout, m_zero}) begin
      errors++;
      $display("FAIL R2 mid-cycle change: actual=%b expected=%b", {res, cout, zero}, {m_res, m_cout, m_zero});
    end
    if (r) begin
      m_res = '0; m_cout = 1'b0; m_zero = 1'b0;
    end else begin
      case (vo)
        3'b000: m_res = va & vb;
        3'b110: begin m_res = va - vb; m_cout = (va >= vb); end
        3'b011: if (va == vb) m_res = '0;
        3'b111: m_cout = 1'b1;
        default: begin m_res = '0; m_cout = 1'b0; end
      endcase
      m_zero = (m_res == 5'd0);
    end
    exp_q.push_back({m_res, m_cout, m_zero});
    tag_q.push_back(r ? "R1" : $sformatf("%s/R8", req_of(r, vo)));
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [6:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({res, cout, zero} !== e) begin
        errors++;
        $display("FAIL %s: actual res=%b cout=%b zero=%b expected res=%b cout=%b zero=%b",
                 t, res, cout, zero, e[6:2], e[1], e[0]);
      end
    end
  end

  initial begin
    apply(1, 5'd3, 5'd7, 3'b110);
    apply(1, 5'd9, 5'd9, 3'b000);
    apply(0, 5'b10110, 5'b01111, 3'b000);   // R3 and
    apply(0, 5'd20, 5'd7, 3'b110);          // R4 no borrow
    apply(0, 5'd3, 5'd9, 3'b110);           // R4 borrow, cout 0
    apply(0, 5'd1, 5'd2, 3'b000);           // R3 carry held at 0, zero set (R8)
    apply(0, 5'd12, 5'd12, 3'b110);         // R4 equal: result 0, cout 1
    apply(0, 5'd7, 5'd5, 3'b000);           // R3 cout held at 1
    apply(0, 5'd4, 5'd6, 3'b011);           // R5 differ: hold
    apply(0, 5'd6, 5'd6, 3'b011);           // R5 equal: clear
    apply(0, 5'd31, 5'd30, 3'b000);
    apply(0, 5'd0, 5'd1, 3'b101);           // R7 clear
    apply(0, 5'd11, 5'd11, 3'b110);
    apply(0, 5'd2, 5'd9, 3'b111);           // R6 result held at 0
    apply(0, 5'd29, 5'd5, 3'b000);
    apply(0, 5'd3, 5'd1, 3'b111);           // R6 result held non-zero
    apply(0, 5'd3, 5'd1, 3'b001);           // R7
    apply(0, 5'd31, 5'd31, 3'b000);
    apply(0, 5'd8, 5'd8, 3'b010);           // R7
    apply(0, 5'd5, 5'd31, 3'b110);
    apply(0, 5'd9, 5'd9, 3'b100);           // R7
    apply(1, 5'd17, 5'd2, 3'b111);          // R1 mid-run reset
    for (int i = 0; i < 120; i++)
      apply(0, 5'((i * 7 + 3) % 32), 5'((i * 13 + 5) % 32), 3'(i % 8));
    for (int i = 0; i < 16; i++)
      apply(0, 5'(i * 2), 5'(i * 2), (i % 2) ? 3'b011 : 3'b110);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule